// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical address by searching a hashed page table in memory. A one-cycle `start` captures the address, the sixteen segment registers, the table base/mask word, the privilege bit, and the fetch/data and write qualifiers. The walker first picks a segment register from the top address nibble. From the virtual segment identifier and the page number it hashes to a primary group of page-table entries, and scans that group one word read at a time.

If no entry in the primary group matches, the walker moves to a secondary group. That group is reached through the one's-complement hash, and its entries must carry the hash-select bit. When an entry matches, its lower word is read. That word gives the real page number, and the protection decode turns it into a rights code. The walk ends with a one-cycle `done`. Reference/change updates, translation caching and fault generation are left to the caller.

Top module: `hpt_walker`

## Requirements
- R1: The primary hash is VSID[18:0] XOR {3'b0, EA[27:12]}, where VSID is bits 23:0 of the segment register chosen by EA[31:28]. The group address for a hash H and table word T is {T[31:25], T[24:16] | (H[18:10] & T[8:0]), H[9:0], 6'b0}. The primary group address is shown on `prim_grp` from the cycle after `start`.
- R2: The secondary group address uses the same formula with H XOR 19'h7FFFF and is shown on `sec_grp`.
- R3: The compare word is {1'b1, VSID[23:0], 1'b0, EA[27:22]}: bit 31 is valid, bit 6 is hash-select and bits 5:0 are the page index. It is shown on `cmp_word`.
- R4: Entry i of a group has its upper word at group+8*i and its lower word at group+8*i+4. Upper words are read in order from i=0, the first read going to the primary group. The walk reads the lower word of the first entry whose upper word equals the compare word, then ends.
- R5: The secondary group is read only after all eight primary entries miss. In the secondary group the compare word has bit 6 set, so a primary entry with bit 6 set never matches in the primary probe.
- R6: If all sixteen entries miss, the walk ends after exactly sixteen reads with `hit`=0, `rights`=0 and `pa`=0.
- R7: On a match, `pa` is {lower[31:12], EA[11:0]} and `hit`=1.
- R8: The segment bits are: bit 30 supervisor key, bit 29 user key. The key is (bit 29 & user) | (bit 30 & ~user). The rights codes are 0 none, 1 read-only, 2 read-write. PP = lower[1:0]. With the key set, PP 0 gives 0, PP 2 gives 2, and PP 1 or 3 gives 1. With the key clear, PP 3 gives 1 and any other PP gives 2. A write turns a read-only result into 0.
- R9: A fetch (`is_instr`=1) that matches gets rights 0 when segment bit 28 (no-execute) or lower bit 3 (guarded) is set.
- R10: `done` is high for exactly one cycle per walk and `busy` is high from the cycle after `start` until `done`. A `start` while busy has no effect on the walk or on the status outputs.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_valid` returns the data. Only one read is outstanding at a time.
- R12: After reset `busy`, `done`, `mem_req` and `hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 32 | Effective address |
| seg_regs | input | 16x32 | Segment registers, index = EA[31:28] |
| tbl_reg | input | 32 | Table origin [31:16] and mask [8:0] |
| user_mode | input | 1 | 1 = user privilege |
| is_instr | input | 1 | 1 = instruction fetch |
| is_write | input | 1 | 1 = store access |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word, big-endian value |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle walk completion |
| hit | output | 1 | A matching entry was found |
| pa | output | 32 | Physical address |
| rights | output | 2 | 0 none, 1 read-only, 2 read-write |
| prim_grp | output | 32 | Primary group address |
| sec_grp | output | 32 | Secondary group address |
| cmp_word | output | 32 | Primary compare word |

## Verification
Two events can fall in the same cycle: a match on the last entry of the primary group, and the end of the primary scan that would move the walk to the secondary group. To provoke this, the bench places the matching entry in slot 7 of the primary group. It then expects a lower-word read and exactly nine reads in total, with no secondary access. A second collision comes from a fresh `start` pulsed while a walk is running. The bench expects that pulse to leave the status outputs and the result of the running walk unchanged.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_PRI, ST_SEC, ST_DONE} walk_state_t;

   localparam int SEG_KS_BIT = 30;
   localparam int SEG_KP_BIT = 29;
   localparam int SEG_NX_BIT = 28;
   localparam int CMP_HSEL_BIT = 6;

   localparam logic [1:0] RGT_NONE = 2'd0;
   localparam logic [1:0] RGT_RO   = 2'd1;
   localparam logic [1:0] RGT_RW   = 2'd2;
endpackage

// File: rtl/hpt_group_addr.sv
module hpt_group_addr #(
   parameter int HASH_W = 19
) (
   input  logic [HASH_W-1:0] hash,
   input  logic [15:0]       origin,
   input  logic [8:0]        mask,
   output logic [31:0]       grp
);
   initial begin
      if (HASH_W != 19) $error("hpt_group_addr: HASH_W must be 19");
   end

   logic [8:0] hi_sel;
   assign hi_sel = hash[18:10] & mask;
   assign grp = {origin[15:9], origin[8:0] | hi_sel, hash[9:0], 6'b0};
endmodule

// File: rtl/hpt_rights.sv
module hpt_rights
   import hpt_pkg::*;
(
   input  logic       key_sup,
   input  logic       key_usr,
   input  logic       no_exec,
   input  logic       guarded,
   input  logic [1:0] pp,
   input  logic       user,
   input  logic       instr,
   input  logic       write,
   output logic [1:0] rights
);
   logic key;
   logic [1:0] base;

   assign key = (key_usr & user) | (key_sup & ~user);

   always_comb begin
      if (key) begin
         unique case (pp)
            2'd0:    base = RGT_NONE;
            2'd2:    base = RGT_RW;
            default: base = RGT_RO;
         endcase
      end else begin
         base = (pp == 2'd3) ? RGT_RO : RGT_RW;
      end
      if (instr && (no_exec || guarded))
         rights = RGT_NONE;
      else if (write && base == RGT_RO)
         rights = RGT_NONE;
      else
         rights = base;
   end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter bit SEC_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [31:0]      vaddr,
   input  logic [15:0][31:0] seg_regs,
   input  logic [31:0]      tbl_reg,
   input  logic             user_mode,
   input  logic             is_instr,
   input  logic             is_write,
   output logic             mem_req,
   output logic [31:0]      mem_addr,
   input  logic             mem_valid,
   input  logic [31:0]      mem_rdata,
   output logic             busy,
   output logic             done,
   output logic             hit,
   output logic [31:0]      pa,
   output logic [1:0]       rights,
   output logic [31:0]      prim_grp,
   output logic [31:0]      sec_grp,
   output logic [31:0]      cmp_word
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
   localparam int PAD_W = 32 - IDX_W - 3;

   generate
      if (!(ENTRIES == 1 || ENTRIES == 2 || ENTRIES == 4 || ENTRIES == 8)) begin : g_bad_entries
         $error("hpt_walker: ENTRIES must be 1, 2, 4 or 8");
      end
   endgenerate

   // Address decomposition and hashing of the incoming request
   logic [31:0] seg_sel;
   logic [18:0] hash_pri;
   logic [31:0] cmp_new;
   logic [31:0] grp_pri_w, grp_sec_w;
   logic        unused_bits;

   assign seg_sel  = seg_regs[vaddr[31:28]];
   assign hash_pri = seg_sel[18:0] ^ {3'b0, vaddr[27:12]};
   assign cmp_new  = {1'b1, seg_sel[23:0], 1'b0, vaddr[27:22]};
   assign unused_bits = ^{tbl_reg[15:9], seg_sel[31], seg_sel[27:24]};

   hpt_group_addr u_grp_pri (
      .hash(hash_pri), .origin(tbl_reg[31:16]), .mask(tbl_reg[8:0]), .grp(grp_pri_w)
   );

   generate
      if (SEC_EN) begin : g_sec
         hpt_group_addr u_grp_sec (
            .hash(hash_pri ^ 19'h7FFFF), .origin(tbl_reg[31:16]), .mask(tbl_reg[8:0]),
            .grp(grp_sec_w)
         );
      end else begin : g_nosec
         assign grp_sec_w = '0;
      end
   endgenerate

   // Walk state
   walk_state_t state;
   logic [IDX_W-1:0] idx;
   logic        lo_phase;
   logic [11:0] off_q;
   logic        ks_q, kp_q, nx_q;
   logic        user_q, instr_q, write_q;
   logic [31:0] cmp_cur;
   logic [31:0] grp_cur;
   logic [1:0]  rights_w;

   assign cmp_cur = (state == ST_SEC) ? (cmp_word | (32'd1 << CMP_HSEL_BIT)) : cmp_word;
   assign grp_cur = (state == ST_SEC) ? sec_grp : prim_grp;
   assign mem_req = (state == ST_PRI) || (state == ST_SEC);
   assign mem_addr = grp_cur + {{PAD_W{1'b0}}, idx, lo_phase, 2'b00};
   assign busy = (state != ST_IDLE);
   assign done = (state == ST_DONE);

   hpt_rights u_rights (
      .key_sup(ks_q), .key_usr(kp_q), .no_exec(nx_q), .guarded(mem_rdata[3]),
      .pp(mem_rdata[1:0]), .user(user_q), .instr(instr_q), .write(write_q),
      .rights(rights_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         lo_phase <= 1'b0;
         off_q    <= '0;
         ks_q     <= 1'b0;
         kp_q     <= 1'b0;
         nx_q     <= 1'b0;
         user_q   <= 1'b0;
         instr_q  <= 1'b0;
         write_q  <= 1'b0;
         hit      <= 1'b0;
         pa       <= '0;
         rights   <= RGT_NONE;
         prim_grp <= '0;
         sec_grp  <= '0;
         cmp_word <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_PRI;
                  idx      <= '0;
                  lo_phase <= 1'b0;
                  off_q    <= vaddr[11:0];
                  ks_q     <= seg_sel[SEG_KS_BIT];
                  kp_q     <= seg_sel[SEG_KP_BIT];
                  nx_q     <= seg_sel[SEG_NX_BIT];
                  user_q   <= user_mode;
                  instr_q  <= is_instr;
                  write_q  <= is_write;
                  prim_grp <= grp_pri_w;
                  sec_grp  <= grp_sec_w;
                  cmp_word <= cmp_new;
               end
            end
            ST_PRI, ST_SEC: begin
               if (mem_valid) begin
                  if (lo_phase) begin
                     hit    <= 1'b1;
                     pa     <= {mem_rdata[31:12], off_q};
                     rights <= rights_w;
                     state  <= ST_DONE;
                  end else if (mem_rdata == cmp_cur) begin
                     lo_phase <= 1'b1;
                  end else if (idx == LAST_IDX) begin
                     idx <= '0;
                     if (state == ST_PRI && SEC_EN) begin
                        state <= ST_SEC;
                     end else begin
                        hit    <= 1'b0;
                        pa     <= '0;
                        rights <= RGT_NONE;
                        state  <= ST_DONE;
                     end
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Checks next to the logic they guard
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
   p_first_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> (mem_addr == prim_grp));
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(prim_grp) && $stable(sec_grp) && $stable(cmp_word)));
   p_miss_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hit) |-> (rights == RGT_NONE && pa == 32'd0));
   p_write_no_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && write_q) |-> (rights != RGT_RO));
   p_rights_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rights != 2'd3));
endmodule

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] vaddr = '0;
   logic [15:0][31:0] seg_regs = '0;
   logic [31:0] tbl_reg = '0;
   logic user_mode = 1'b0, is_instr = 1'b0, is_write = 1'b0;
   logic mem_req;
   logic [31:0] mem_addr;
   logic mem_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic busy, done, hit;
   logic [31:0] pa, prim_grp, sec_grp, cmp_word;
   logic [1:0] rights;

   int n_chk = 0, n_err = 0, n_reads = 0, lat = 0;
   logic [31:0] tab_a [0:63];
   logic [31:0] tab_d [0:63];
   int tab_n = 0;

   always #5 clk = ~clk;

   hpt_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .seg_regs(seg_regs),
      .tbl_reg(tbl_reg), .user_mode(user_mode), .is_instr(is_instr), .is_write(is_write),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .hit(hit), .pa(pa), .rights(rights),
      .prim_grp(prim_grp), .sec_grp(sec_grp), .cmp_word(cmp_word)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_rd(input logic [31:0] a);
      for (int i = 0; i < tab_n; i++) if (tab_a[i] == a) return tab_d[i];
      return 32'd0;
   endfunction

   task automatic mem_wr(input logic [31:0] a, input logic [31:0] d);
      for (int i = 0; i < tab_n; i++) if (tab_a[i] == a) begin tab_d[i] = d; return; end
      tab_a[tab_n] = a; tab_d[tab_n] = d; tab_n++;
   endtask

   // Memory model: random latency 0..2, data driven at the falling edge
   always @(negedge clk) begin
      mem_valid = 1'b0;
      if (mem_req) begin
         if (lat == 0) begin
            mem_valid = 1'b1;
            mem_rdata = mem_rd(mem_addr);
            n_reads++;
            lat = $urandom % 3;
         end else lat--;
      end
   end

   function automatic logic [31:0] f_grp(input logic [18:0] h, input logic [31:0] t);
      return {t[31:25], t[24:16] | (h[18:10] & t[8:0]), h[9:0], 6'b0};
   endfunction

   function automatic logic [1:0] f_rights(input logic [31:0] lo, input logic [31:0] sg,
                                          input logic u, input logic ins, input logic wr);
      logic key; logic [1:0] r;
      key = (sg[29] & u) | (sg[30] & ~u);
      if (ins && (sg[28] || lo[3])) return 2'd0;
      if (key) r = (lo[1:0] == 2'd0) ? 2'd0 : (lo[1:0] == 2'd2) ? 2'd2 : 2'd1;
      else     r = (lo[1:0] == 2'd3) ? 2'd1 : 2'd2;
      if (wr && r == 2'd1) r = 2'd0;
      return r;
   endfunction

   // kind: 0 miss, 1 primary hit, 2 secondary hit; slot 0..7; busy_poke restarts during walk
   task automatic walk(input int kind, input int slot, input logic [31:0] lo,
                       input bit busy_poke, input string tag);
      logic [31:0] sg, cmp, gp, gs, lo_w;
      logic [18:0] h;
      int exp_reads, cyc;
      sg  = seg_regs[vaddr[31:28]];
      h   = sg[18:0] ^ {3'b0, vaddr[27:12]};
      cmp = {1'b1, sg[23:0], 1'b0, vaddr[27:22]};
      gp  = f_grp(h, tbl_reg);
      gs  = f_grp(h ^ 19'h7FFFF, tbl_reg);
      tab_n = 0;
      // decoys: hash-select set in primary, invalid copy, hash-select clear in secondary
      mem_wr(gp + 32'd8 * ((slot + 3) % 8), cmp | 32'h40);
      mem_wr(gp + 32'd8 * ((slot + 5) % 8), cmp & 32'h7FFF_FFFF);
      mem_wr(gs + 32'd8 * ((slot + 2) % 8), cmp);
      mem_wr(gs + 32'd8 * ((slot + 6) % 8), (cmp | 32'h40) & 32'h7FFF_FFFF);
      lo_w = lo;
      if (kind == 1) begin
         mem_wr(gp + 32'd8 * slot, cmp); mem_wr(gp + 32'd8 * slot + 4, lo_w);
         exp_reads = slot + 2;
      end else if (kind == 2) begin
         mem_wr(gs + 32'd8 * slot, cmp | 32'h40); mem_wr(gs + 32'd8 * slot + 4, lo_w);
         exp_reads = 8 + slot + 2;
      end else exp_reads = 16;
      @(negedge clk); start = 1'b1; n_reads = 0;
      @(negedge clk); start = 1'b0;
      chk({tag, " R10 busy"}, {31'd0, busy}, 32'd1);
      if (busy_poke) begin
         @(negedge clk); start = 1'b1; vaddr = ~vaddr;
         @(negedge clk); start = 1'b0; vaddr = ~vaddr;
      end
      cyc = 0;
      while (!done && cyc < 200) begin @(negedge clk); cyc++; end
      chk({tag, " R10 done seen"}, {31'd0, done}, 32'd1);
      chk({tag, " R1 prim_grp"}, prim_grp, gp);
      chk({tag, " R2 sec_grp"}, sec_grp, gs);
      chk({tag, " R3 cmp_word"}, cmp_word, cmp);
      chk({tag, " R5 R6 read count"}, n_reads, exp_reads);
      if (kind == 0) begin
         chk({tag, " R6 hit"}, {31'd0, hit}, 32'd0);
         chk({tag, " R6 pa"}, pa, 32'd0);
         chk({tag, " R6 rights"}, {30'd0, rights}, 32'd0);
      end else begin
         chk({tag, " R4 hit"}, {31'd0, hit}, 32'd1);
         chk({tag, " R7 pa"}, pa, {lo_w[31:12], vaddr[11:0]});
         chk({tag, " R8 R9 rights"}, {30'd0, rights},
             {30'd0, f_rights(lo_w, sg, user_mode, is_instr, is_write)});
      end
      @(negedge clk);
      chk({tag, " R10 done one cycle"}, {31'd0, done}, 32'd0);
   endtask

   task automatic rand_ctx();
      for (int i = 0; i < 16; i++) seg_regs[i] = $urandom;
      vaddr = $urandom; tbl_reg = $urandom;
      user_mode = $urandom; is_instr = $urandom; is_write = $urandom;
   endtask

   initial begin
      #(10 * 150000);
      n_err++; n_chk++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R12 busy", {31'd0, busy}, 32'd0);
      chk("R12 done", {31'd0, done}, 32'd0);
      chk("R12 mem_req", {31'd0, mem_req}, 32'd0);
      chk("R12 hit", {31'd0, hit}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed: match in last primary slot (R4, R5)
      rand_ctx(); is_instr = 0; is_write = 0;
      walk(1, 7, 32'hABCDE002, 0, "dir_pri_last");
      rand_ctx(); walk(2, 7, 32'h12345001, 0, "dir_sec_last");
      rand_ctx(); walk(0, 0, 32'h0, 0, "dir_miss");
      rand_ctx(); walk(1, 0, 32'h55555000, 0, "dir_pri_first");
      // R9: no-execute segment, and guarded page
      rand_ctx(); is_instr = 1; is_write = 0;
      seg_regs[vaddr[31:28]][28] = 1'b1;
      walk(1, 2, 32'h00001002, 0, "dir_r9_nx");
      rand_ctx(); is_instr = 1; is_write = 0;
      seg_regs[vaddr[31:28]][28] = 1'b0;
      walk(1, 3, 32'h00002008, 0, "dir_r9_guard");
      // R8: all key/pp/write combinations
      for (int k = 0; k < 2; k++)
         for (int p = 0; p < 4; p++)
            for (int w = 0; w < 2; w++) begin
               rand_ctx(); is_instr = 0; is_write = w[0]; user_mode = 1'b1;
               seg_regs[vaddr[31:28]][29] = k[0];
               walk(1, p, {20'h0F0F0, 10'd0, p[1:0]}, 0, "dir_r8_key");
            end
      // R10: start while busy has no effect
      rand_ctx(); walk(2, 4, 32'hFEDCB002, 1, "dir_busy_start");
      // Random mix
      for (int n = 0; n < 40; n++) begin
         rand_ctx();
         walk($urandom % 3, $urandom % 8, $urandom, ($urandom % 4) == 0, "rnd");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule